// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block recovers stereo samples from a three-wire serial audio stream made of a bit clock, a word clock that marks the channel, and a data line. A system clock that runs much faster than the bit clock samples all three wires. Each wire passes through a two-stage synchronizer, and the receiver acts on the detected rising edges of the synchronized bit clock. Each rising edge shifts one data bit into a shift register and compares the word clock with its value at the previous edge.

A three-bit format code picks one of six framings:
- right-justified words of 16, 20 or 24 bits, which end on the last bit before the word-clock change;
- a 24-bit left-justified word that starts right at the change;
- I2S words of 16 or 24 bits, whose MSB follows the change by one bit clock.

The words are widened to 24 bits with the sign bit. Once a left word and then a right word of the same frame have been captured, both appear together with a one-cycle valid strobe. The two remaining codes are reserved: on them the receiver stays silent.

Top module: `aud_ser_rx`

## Requirements
- R1: The format code `fmt_i` is read as `fmt_i[2:1]` = length/justification field and `fmt_i[0]` = I2S select. The codes are: 000 = right-justified 16 bits, 010 = right-justified 20 bits, 100 = right-justified 24 bits, 110 = left-justified 24 bits, 001 = I2S 16 bits, 011 = I2S 24 bits.
- R2: In right-justified modes the word is the last N data bits sampled before the rising bit-clock edge at which the word clock is first seen changed, and word clock high marks the left channel.
- R3: In left-justified mode the MSB is the bit sampled at the first rising bit-clock edge that sees the changed word clock, the next N-1 bits follow MSB first, and word clock high marks the left channel.
- R4: In I2S modes the MSB is the bit sampled one bit clock after the edge that sees the word-clock change, and word clock low marks the left channel.
- R5: Every captured word of N bits is presented on 24 bits, with bits 23 down to N copies of bit N-1.
- R6: While the code is 101 or 111, `valid_o` stays low and `left_o` and `right_o` read zero from the cycle after the code is applied.
- R7: `valid_o` pulses for exactly one cycle once per frame, when the right word that follows a captured left word is taken. It then carries that left/right pair. A right word with no left word before it is dropped.
- R8: `valid_o` rises 3 system-clock cycles after the bit-clock rise that completes the frame: two synchronizer stages plus one output register.
- R9: After reset, `valid_o` is low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Serial word (frame) clock |
| sdata_i | input | 1 | Serial data |
| fmt_i | input | 3 | Framing code, see R1 |
| left_o | output | OUT_W (24) | Sign-extended left sample |
| right_o | output | OUT_W (24) | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
A new sample pair is due exactly three system clocks after the bit-clock rise that completes the frame. For right-justified framings that rise is the one at the next word-clock change; for the other framings it is the rise that carries the right word's LSB. The bench stamps the cycle of every bit-clock rise it drives and samples `valid_o` on falling clock edges. At each strobe it checks that the gap is three cycles and that no strobe lasts longer than one cycle. Sample values are compared only at those strobes. The reserved-code checks are read back several bit periods after the code is applied, well past the single cycle the outputs need to clear.

// File: rtl/asr_pkg.sv
package asr_pkg;

   typedef enum logic [1:0] {
      JUST_RIGHT = 2'd0,
      JUST_LEFT  = 2'd1,
      JUST_I2S   = 2'd2,
      JUST_NONE  = 2'd3
   } asr_just_e;

   typedef struct packed {
      asr_just_e  just;
      logic [4:0] wlen;
   } asr_cfg_t;

   function automatic asr_cfg_t asr_decode(input logic [2:0] code);
      asr_cfg_t c;
      case (code)
         3'b000:  begin c.just = JUST_RIGHT; c.wlen = 5'd16; end
         3'b010:  begin c.just = JUST_RIGHT; c.wlen = 5'd20; end
         3'b100:  begin c.just = JUST_RIGHT; c.wlen = 5'd24; end
         3'b110:  begin c.just = JUST_LEFT;  c.wlen = 5'd24; end
         3'b001:  begin c.just = JUST_I2S;   c.wlen = 5'd16; end
         3'b011:  begin c.just = JUST_I2S;   c.wlen = 5'd24; end
         default: begin c.just = JUST_NONE;  c.wlen = 5'd24; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/asr_edge_track.sv
module asr_edge_track #(
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             bclk_s_i,
   input  logic             ws_s_i,
   output logic             tick_o,
   output logic             bound_o,
   output logic             locked_o,
   output logic [POS_W-1:0] pos_o
);
   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

   logic             bclk_d;
   logic             ws_prev;
   logic             locked_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_nx;

   assign tick_o   = bclk_s_i & ~bclk_d;
   assign bound_o  = tick_o & (ws_s_i != ws_prev);
   assign locked_o = locked_q;

   always_comb begin
      if (bound_o)               pos_nx = '0;
      else if (pos_q == POS_MAX) pos_nx = POS_MAX;
      else                       pos_nx = pos_q + 1'b1;
   end
   assign pos_o = pos_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d   <= 1'b0;
         ws_prev  <= 1'b0;
         locked_q <= 1'b0;
         pos_q    <= POS_MAX;
      end else begin
         bclk_d <= bclk_s_i;
         if (clr_i) begin
            locked_q <= 1'b0;
            pos_q    <= POS_MAX;
         end else if (tick_o) begin
            ws_prev <= ws_s_i;
            pos_q   <= pos_nx;
            if (bound_o) locked_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/asr_capture.sv
module asr_capture
   import asr_pkg::*;
#(
   parameter int OUT_W = 24,
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  asr_cfg_t         cfg_i,
   input  logic             tick_i,
   input  logic             bound_i,
   input  logic             locked_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             sd_i,
   input  logic             ws_i,
   output logic             cap_l_o,
   output logic             cap_r_o,
   output logic [OUT_W-1:0] word_o
);
   logic [OUT_W-1:0] sr;
   logic [OUT_W-1:0] raw;
   logic [POS_W-1:0] n_pos;
   logic             hit;
   logic             is_left;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      sr <= '0;
      else if (tick_i) sr <= {sr[OUT_W-2:0], sd_i};

   // right-justified words are complete before the current bit arrives
   assign raw   = (cfg_i.just == JUST_RIGHT) ? sr : {sr[OUT_W-2:0], sd_i};
   assign n_pos = POS_W'(cfg_i.wlen);

   always_comb begin
      for (int i = 0; i < OUT_W; i++)
         word_o[i] = (i < int'(cfg_i.wlen)) ? raw[i] : raw[cfg_i.wlen - 5'd1];
   end

   always_comb begin
      case (cfg_i.just)
         JUST_RIGHT: hit = tick_i & bound_i & locked_i;
         JUST_LEFT:  hit = tick_i & locked_i & (pos_i == n_pos - 1'b1);
         JUST_I2S:   hit = tick_i & locked_i & (pos_i == n_pos);
         default:    hit = 1'b0;
      endcase
      is_left = (cfg_i.just == JUST_LEFT) ? ws_i : ~ws_i;
   end

   assign cap_l_o = hit & is_left;
   assign cap_r_o = hit & ~is_left;
endmodule

// File: rtl/asr_pair_out.sv
module asr_pair_out #(
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             rsvd_i,
   input  logic             cap_l_i,
   input  logic             cap_r_i,
   input  logic [OUT_W-1:0] word_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   logic [OUT_W-1:0] hold_l;
   logic             have_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l  <= '0;
         have_l  <= 1'b0;
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else if (rsvd_i) begin
         hold_l  <= '0;
         have_l  <= 1'b0;
         left_o  <= '0;
         right_o <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clr_i) begin
            have_l <= 1'b0;
         end else if (cap_l_i) begin
            hold_l <= word_i;
            have_l <= 1'b1;
         end else if (cap_r_i && have_l) begin
            left_o  <= hold_l;
            right_o <= word_i;
            valid_o <= 1'b1;
            have_l  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
   import asr_pkg::*;
#(
   parameter int OUT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int POS_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             wclk_i,
   input  logic             sdata_i,
   input  logic [2:0]       fmt_i,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   if (OUT_W < 24) begin : g_chk_w
      $error("OUT_W must hold a 24-bit word");
   end
   if (SYNC_STAGES < 2) begin : g_chk_s
      $error("SYNC_STAGES must be at least 2");
   end
   if ((2 ** POS_W) - 1 <= 25) begin : g_chk_p
      $error("POS_W too small for a 24-bit I2S word");
   end

   logic [2:0]       fmt_q;
   logic             fmt_chg;
   asr_cfg_t         cfg;
   logic             rsvd;
   logic [2:0]       sync_q;
   logic             edge_tick;
   logic             edge_bound;
   logic             edge_locked;
   logic [POS_W-1:0] edge_pos;
   logic             cap_l;
   logic             cap_r;
   logic [OUT_W-1:0] cap_word;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) fmt_q <= 3'b000;
      else        fmt_q <= fmt_i;

   assign fmt_chg = (fmt_i != fmt_q);
   assign cfg     = asr_decode(fmt_i);
   assign rsvd    = (cfg.just == JUST_NONE);

   asr_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bclk_i, wclk_i, sdata_i}),
      .q_o   (sync_q)
   );

   asr_edge_track #(.POS_W(POS_W)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (fmt_chg),
      .bclk_s_i (sync_q[2]),
      .ws_s_i   (sync_q[1]),
      .tick_o   (edge_tick),
      .bound_o  (edge_bound),
      .locked_o (edge_locked),
      .pos_o    (edge_pos)
   );

   asr_capture #(.OUT_W(OUT_W), .POS_W(POS_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_i    (cfg),
      .tick_i   (edge_tick),
      .bound_i  (edge_bound),
      .locked_i (edge_locked),
      .pos_i    (edge_pos),
      .sd_i     (sync_q[0]),
      .ws_i     (sync_q[1]),
      .cap_l_o  (cap_l),
      .cap_r_o  (cap_r),
      .word_o   (cap_word)
   );

   asr_pair_out #(.OUT_W(OUT_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (fmt_chg),
      .rsvd_i  (rsvd),
      .cap_l_i (cap_l),
      .cap_r_i (cap_r),
      .word_i  (cap_word),
      .left_o  (left_o),
      .right_o (right_o),
      .valid_o (valid_o)
   );
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       fmt_i,
   input logic [OUT_W-1:0] left_o,
   input logic [OUT_W-1:0] right_o,
   input logic             valid_o,
   input logic             tick
);
   logic rsvd;
   assign rsvd = fmt_i[2] & fmt_i[0];

   AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsvd && $past(rsvd)) |-> (!valid_o && left_o == '0 && right_o == '0)); // R6

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R7

   AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(tick)); // R8

   AST_SEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && fmt_i[2:1] == 2'b00 && $past(fmt_i) == fmt_i) |->
      ((&left_o[OUT_W-1:15] || ~|left_o[OUT_W-1:15]) &&
       (&right_o[OUT_W-1:15] || ~|right_o[OUT_W-1:15]))); // R5

   AST_SEXT_20: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && fmt_i == 3'b010 && $past(fmt_i) == fmt_i) |->
      ((&left_o[OUT_W-1:19] || ~|left_o[OUT_W-1:19]) &&
       (&right_o[OUT_W-1:19] || ~|right_o[OUT_W-1:19]))); // R5
endmodule

bind aud_ser_rx aud_ser_rx_chk #(.OUT_W(OUT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .fmt_i   (fmt_i),
   .left_o  (left_o),
   .right_o (right_o),
   .valid_o (valid_o),
   .tick    (edge_tick)
);

// File: tb/aud_ser_rx_tb_top.sv
module aud_ser_rx_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        wclk = 1'b0;
   logic        sdata = 1'b0;
   logic [2:0]  fmt = 3'b000;
   logic [23:0] left_o;
   logic [23:0] right_o;
   logic        valid_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int last_rise = 0;
   int got_n = 0;
   int wide_pulse = 0;
   logic prev_v = 1'b0;
   logic [23:0] got_l [8];
   logic [23:0] got_r [8];
   int got_lat [8];
   logic [23:0] exp_l [3];
   logic [23:0] exp_r [3];

   always #5 clk = ~clk;

   aud_ser_rx dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk),
      .wclk_i  (wclk),
      .sdata_i (sdata),
      .fmt_i   (fmt),
      .left_o  (left_o),
      .right_o (right_o),
      .valid_o (valid_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (valid_o) begin
         if (got_n < 8) begin
            got_l[got_n]   = left_o;
            got_r[got_n]   = right_o;
            got_lat[got_n] = cyc - last_rise;
         end
         got_n++;
         if (prev_v) wide_pulse++;
      end
      prev_v = valid_o;
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] sext(input logic [23:0] v, input int n);
      logic [23:0] r = v;
      for (int i = n; i < 24; i++) r[i] = v[n-1];
      return r;
   endfunction

   // mode: 0 right-justified, 1 left-justified, 2 I2S; 32-bit slots
   function automatic logic slot_bit(input int mode, input int n, input int j,
                                     input logic [23:0] v);
      if (mode == 1) return (j < n) ? v[n-1-j] : 1'b0;
      if (mode == 2) return (j >= 1 && j <= n) ? v[n-j] : 1'b0;
      return (j >= 32 - n) ? v[31-j] : 1'b0;
   endfunction

   task automatic send_bit(input logic ws, input logic d);
      @(negedge clk);
      bclk = 1'b0; wclk = ws; sdata = d;
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      last_rise = cyc;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_frames(input int mode, input int n, input logic lhi);
      logic [23:0] mask = (24'h1 << n) - 24'h1;
      for (int i = 0; i < 4; i++) send_bit(~lhi, 1'b0);
      for (int k = 0; k < 3; k++) begin
         logic [23:0] lv = (24'h9ABCDE + k * 24'h13579B) & mask;
         logic [23:0] rv = (24'h3C5A71 + k * 24'h2468AC) & mask;
         exp_l[k] = sext(lv, n);
         exp_r[k] = sext(rv, n);
         for (int j = 0; j < 32; j++) send_bit(lhi, slot_bit(mode, n, j, lv));
         for (int j = 0; j < 32; j++) send_bit(~lhi, slot_bit(mode, n, j, rv));
      end
      send_bit(lhi, 1'b0);
      send_bit(lhi, 1'b0);
      repeat (10) @(negedge clk);
   endtask

   task automatic run_format(input logic [2:0] code, input int mode, input int n,
                             input logic lhi, input string req);
      fmt = code;
      repeat (4) @(negedge clk);
      got_n = 0;
      wide_pulse = 0;
      send_frames(mode, n, lhi);
      check({req, " R7"}, "pairs delivered", got_n, 3);
      check("R7", "strobe wider than one cycle", wide_pulse, 0);
      for (int k = 0; k < 3 && k < got_n; k++) begin
         check({req, " R1 R5"}, $sformatf("left word %0d", k), got_l[k], exp_l[k]);
         check({req, " R1 R5"}, $sformatf("right word %0d", k), got_r[k], exp_r[k]);
         check("R8", $sformatf("latency of pair %0d", k), got_lat[k], 3);
      end
   endtask

   task automatic run_reserved(input logic [2:0] code);
      fmt = code;
      repeat (4) @(negedge clk);
      got_n = 0;
      send_frames(0, 16, 1'b1);
      check("R6", "pairs on reserved code", got_n, 0);
      check("R6", "left output on reserved code", left_o, 0);
      check("R6", "right output on reserved code", right_o, 0);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      check("R9", "valid in reset", valid_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R9", "valid after reset", valid_o, 0);
      check("R9", "left after reset", left_o, 0);
      check("R9", "right after reset", right_o, 0);
   endtask

   initial begin
      test_reset();
      run_format(3'b000, 0, 16, 1'b1, "R2 rj16");
      run_format(3'b010, 0, 20, 1'b1, "R2 rj20");
      run_format(3'b100, 0, 24, 1'b1, "R2 rj24");
      run_format(3'b110, 1, 24, 1'b1, "R3 lj24");
      run_format(3'b001, 2, 16, 1'b0, "R4 i2s16");
      run_format(3'b011, 2, 24, 1'b0, "R4 i2s24");
      run_reserved(3'b101);
      run_reserved(3'b111);
      run_format(3'b000, 0, 16, 1'b1, "R2 rj16 after reserved");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule